// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt lines, keeps a request register, an in-service register and a mask register, and raises one request toward the processor when a pending unmasked line outranks every line already in service. The priority order is a ring of eight whose top position (the base) software can move. When the processor acknowledges, the winning line moves from pending to in service. It leaves service when software sends one of the end-of-service commands.

Software uses a byte-wide register port. Address 0 is the command port. Address 1 is the data port, which takes the setup words and then the mask. Address 2 holds the per-line trigger mode. A setup sequence gives the vector base and the operating options. Later command writes end service, move the priority base, choose which register a read of address 0 returns, or arm a one-shot poll read. While the block is requesting, `vecOut` shows the vector base combined with the winning line number.

Top module: `pic_top`

## Requirements
- R1: A command-port write with bit 4 set starts setup. It clears request, in-service, mask, trigger, base, poll and read-select state, and `intReq` is low in the cycle after the write. Bit 1 set means no third setup word. Bit 0 set means a fourth word follows. If bit 0 is clear, the next data-port write after the second word loads the mask.
- R2: The second setup word sets the vector base to the written value AND 0xF8. `vecOut` equals that base OR the winning line number.
- R3: A data-port write outside setup loads the mask. A masked line still sets its request bit, which can be read back, but it never drives `intReq`. The mask reads back at address 1.
- R4: Address 2 holds the trigger register. A write keeps only the bits allowed by `TRIG_MASK` (0xF8 by default). A line with its bit at 1 is level triggered: its request bit follows the input. A line with its bit at 0 sets its request bit on a rising input, and the bit stays set after the input falls.
- R5: A line's rank is (line − base) mod 8, and rank 0 is the highest priority. `intReq` is high when the best-ranked pending unmasked line ranks strictly above the best-ranked in-service line, or when no line is in service.
- R6: A pulse on `intAck` while `intReq` is high clears the winner's request bit and sets its in-service bit. If auto-end was chosen (fourth setup word, bit 1), the in-service bit is not set.
- R7: A command write with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-ranked in-service bit. Code 101 does the same and also sets the base to that line + 1 mod 8.
- R8: Command code 011 clears the in-service bit named by bits 2:0. Code 111 does the same and also sets the base to that line + 1 mod 8. Code 110 only sets the base to line + 1 mod 8.
- R9: A command write with bit 4 = 0 and bit 3 = 1 is a read/poll control word. Bit 2 arms a poll. Bit 1 enables bit 0 as read-select: 1 makes address 0 return the in-service register, 0 makes it return the request register.
- R10: When a poll is armed, a read of address 0 returns the winning line number and clears its request and in-service bits. It returns 0x07 when nothing qualifies. One read ends the poll.
- R11: Nested mode (fourth setup word, bit 4) on a master unit leaves in-service bit 2 out of the priority comparison, so a lower-ranked line can still request while line 2 is in service.
- R12: An active-low `rstN` clears all state, and `intReq` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | 8 | Interrupt lines |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (poll side effect) |
| addr | input | 2 | 0 command, 1 data/mask, 2 trigger |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| intAck | input | 1 | Processor acknowledge pulse |
| intReq | output | 1 | Interrupt request to processor |
| vecOut | output | 8 | Vector base OR winning line |

## Verification
The hardest case to reach is one where the base has been moved by a rotating end command and the outcome differs from the unrotated order. To reach it, the stimulus services a line, ends it with code 111, and then raises that same line again next to a normally weaker one, so the weaker line must win. Nested mode takes a similar effort: line 2 is put in service first, and then a lower-ranked line is raised both with and without the option. Random rounds draw the mask, the base and the levels on the lines that can be level triggered.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int LINES = 8;
  localparam int LW = $clog2(LINES);
  typedef logic [LW-1:0] line_t;

  typedef struct packed {
    logic       clearAll;
    logic       wrImr;
    logic       wrTrig;
    logic       eoiTop;
    logic       eoiLine;
    logic       setBase;
    logic       baseFromTop;
    logic       pollTake;
    line_t      line;
    logic [7:0] data;
  } ctlStrobe_t;

  // returns {found, rank} of best-ranked set bit, ring starting at base
  function automatic logic [LW:0] topScan(input logic [LINES-1:0] vec, input line_t base);
    logic [LW:0] r;
    r = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (vec[line_t'(base + line_t'(k))]) r = {1'b1, line_t'(k)};
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_dp.sv
`timescale 1ns/1ps
module pic_dp
  import pic_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  ctlStrobe_t       ctl,
  input  logic             intAck,
  input  logic             autoEoi,
  input  logic             nestMode,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr,
  output logic [LINES-1:0] imr,
  output logic [LINES-1:0] elcr,
  output logic             reqOk,
  output line_t            winLine,
  output logic [7:0]       pollByte
);
  logic [LINES-1:0] lastIn;
  line_t base;
  logic [LW:0] pendScan, isrCmpScan, isrTopScan;
  logic [LINES-1:0] isrCmpVec, irrNext, isrNext;
  line_t topIsrLine, baseNext;
  logic take;

  always_comb begin
    isrCmpVec = isr;
    if (IS_MASTER && nestMode) isrCmpVec[CASC_LINE] = 1'b0;
    pendScan   = topScan(irr & ~imr, base);
    isrCmpScan = topScan(isrCmpVec, base);
    isrTopScan = topScan(isr, base);
    winLine    = base + pendScan[LW-1:0];
    topIsrLine = base + isrTopScan[LW-1:0];
    reqOk = pendScan[LW] && (!isrCmpScan[LW] || (pendScan[LW-1:0] < isrCmpScan[LW-1:0]));
    pollByte = reqOk ? {{(8-LW){1'b0}}, winLine} : 8'h07;
    take = (intAck || ctl.pollTake) && reqOk;
  end

  always_comb begin
    irrNext = irr;
    if (take) irrNext[winLine] = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (elcr[i]) irrNext[i] = irqIn[i];
      else if (irqIn[i] && !lastIn[i]) irrNext[i] = 1'b1;
    end
    isrNext = isr;
    if (intAck && reqOk && !autoEoi) isrNext[winLine] = 1'b1;
    if (ctl.pollTake && reqOk) isrNext[winLine] = 1'b0;
    if (ctl.eoiTop && isrTopScan[LW]) isrNext[topIsrLine] = 1'b0;
    if (ctl.eoiLine) isrNext[ctl.line] = 1'b0;
    baseNext = base;
    if (ctl.setBase) baseNext = ctl.line + line_t'(1);
    else if (ctl.baseFromTop && isrTopScan[LW]) baseNext = topIsrLine + line_t'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr <= '0; isr <= '0; imr <= '0; elcr <= '0; lastIn <= '0; base <= '0;
    end else if (ctl.clearAll) begin
      irr <= '0; isr <= '0; imr <= '0; elcr <= '0; lastIn <= '0; base <= '0;
    end else begin
      irr    <= irrNext;
      isr    <= isrNext;
      base   <= baseNext;
      lastIn <= irqIn;
      if (ctl.wrImr) imr <= ctl.data;
      if (ctl.wrTrig) elcr <= ctl.data & TRIG_MASK;
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [7:0]       wrData,
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] isr,
  input  logic [LINES-1:0] imr,
  input  logic [LINES-1:0] elcr,
  input  logic [7:0]       pollByte,
  output ctlStrobe_t       ctl,
  output logic [7:0]       rdData,
  output logic             autoEoi,
  output logic             nestMode,
  output logic             pollOn,
  output logic             inInit,
  output logic [7:0]       vecBase
);
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} initSt_t;
  initSt_t state;
  logic needMode, single, readIsr;
  logic cmdWr, startInit, ctlWord, eoiWord, dataWr;

  always_comb begin
    cmdWr     = wrEn && (addr == 2'd0);
    dataWr    = wrEn && (addr == 2'd1);
    startInit = cmdWr && wrData[4];
    ctlWord   = cmdWr && !wrData[4] && wrData[3];
    eoiWord   = cmdWr && !wrData[4] && !wrData[3];
    inInit    = (state != ST_RUN);
    ctl = '0;
    ctl.clearAll = startInit;
    ctl.wrImr    = dataWr && (state == ST_RUN);
    ctl.wrTrig   = wrEn && (addr == 2'd2);
    ctl.pollTake = rdEn && (addr == 2'd0) && pollOn;
    ctl.line     = wrData[LW-1:0];
    ctl.data     = wrData;
    if (eoiWord) begin
      unique case (wrData[7:5])
        3'b001: ctl.eoiTop = 1'b1;
        3'b101: begin ctl.eoiTop = 1'b1; ctl.baseFromTop = 1'b1; end
        3'b011: ctl.eoiLine = 1'b1;
        3'b111: begin ctl.eoiLine = 1'b1; ctl.setBase = 1'b1; end
        3'b110: ctl.setBase = 1'b1;
        default: ;
      endcase
    end
    unique case (addr)
      2'd0:    rdData = pollOn ? pollByte : (readIsr ? isr : irr);
      2'd1:    rdData = imr;
      2'd2:    rdData = elcr;
      default: rdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN; needMode <= 1'b0; single <= 1'b0; autoEoi <= 1'b0;
      nestMode <= 1'b0; readIsr <= 1'b0; pollOn <= 1'b0; vecBase <= '0;
    end else if (startInit) begin
      state <= ST_BASE; needMode <= wrData[0]; single <= wrData[1];
      autoEoi <= 1'b0; nestMode <= 1'b0; readIsr <= 1'b0; pollOn <= 1'b0; vecBase <= '0;
    end else begin
      if (ctl.pollTake) pollOn <= 1'b0;
      if (ctlWord) begin
        if (wrData[2]) pollOn <= 1'b1;
        if (wrData[1]) readIsr <= wrData[0];
      end
      if (dataWr) begin
        unique case (state)
          ST_BASE: begin
            vecBase <= wrData & 8'hF8;
            state <= !single ? ST_CASC : (needMode ? ST_MODE : ST_RUN);
          end
          ST_CASC: state <= needMode ? ST_MODE : ST_RUN;
          ST_MODE: begin
            autoEoi <= wrData[1]; nestMode <= wrData[4]; state <= ST_RUN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_top.sv
`timescale 1ns/1ps
module pic_top
  import pic_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       intAck,
  output logic       intReq,
  output logic [7:0] vecOut
);
  ctlStrobe_t ctl;
  logic [LINES-1:0] irr, isr, imr, elcr;
  logic reqOk, autoEoi, nestMode, pollOn, inInit;
  line_t winLine;
  logic [7:0] pollByte, vecBase;

  pic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .irr(irr), .isr(isr), .imr(imr), .elcr(elcr), .pollByte(pollByte),
    .ctl(ctl), .rdData(rdData), .autoEoi(autoEoi), .nestMode(nestMode),
    .pollOn(pollOn), .inInit(inInit), .vecBase(vecBase)
  );

  pic_dp #(.TRIG_MASK(TRIG_MASK), .IS_MASTER(IS_MASTER), .CASC_LINE(CASC_LINE)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ctl(ctl), .intAck(intAck),
    .autoEoi(autoEoi), .nestMode(nestMode), .irr(irr), .isr(isr), .imr(imr),
    .elcr(elcr), .reqOk(reqOk), .winLine(winLine), .pollByte(pollByte)
  );

  assign intReq = reqOk;
  assign vecOut = vecBase | {{(8-LW){1'b0}}, winLine};
endmodule

// File: rtl/pic_chk.sv
`timescale 1ns/1ps
module pic_chk #(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic       intAck,
  input logic       intReq,
  input logic [2:0] winLine,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic [7:0] elcr,
  input logic       autoEoi,
  input logic       pollOn,
  input logic       inInit
);
  p_init_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && wrData[4]) |=> !intReq);

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && !inInit) |=> (imr == $past(wrData)));

  p_trig_allowed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (elcr & ~TRIG_MASK) == 8'h00);

  p_req_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (irr[winLine] && !imr[winLine]));

  p_ack_service_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq && !autoEoi && !wrEn && !rdEn) |=> isr[$past(winLine)]);

  p_poll_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd0 && pollOn && intReq && !intAck && !wrEn) |=> !isr[$past(winLine)]);
endmodule

bind pic_top pic_chk #(.TRIG_MASK(TRIG_MASK)) i_pic_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .intAck(intAck), .intReq(intReq), .winLine(winLine), .irr(irr), .isr(isr),
  .imr(imr), .elcr(elcr), .autoEoi(autoEoi), .pollOn(pollOn), .inInit(inInit)
);

// File: tb/test_pic_top.sv
`timescale 1ns/1ps
module test_pic_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, intAck = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, vecOut;
  logic intReq;
  int total = 0, bad = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  pic_top i_pic_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .intAck(intAck), .intReq(intReq), .vecOut(vecOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ackPulse();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic setIrq(input int line, input logic v);
    @(negedge clk); irqIn[line] = v;
    @(negedge clk);
  endtask

  task automatic initPic(input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w4);
    irqIn = '0;
    @(negedge clk);
    wr(2'd0, w1);
    wr(2'd1, w2);
    if (!w1[1]) wr(2'd1, 8'h00);
    if (w1[0]) wr(2'd1, w4);
  endtask

  function automatic int expWin(input logic [7:0] pend, input int base);
    for (int k = 0; k < 8; k++) if (pend[(base + k) % 8]) return (base + k) % 8;
    return -1;
  endfunction

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R12 reset intReq", {7'd0, intReq}, 8'h00);
    rstN = 1'b1;
    rd(2'd1, got); check("R12 reset mask", got, 8'h00);
    rd(2'd2, got); check("R12 reset trigger", got, 8'h00);
    rd(2'd0, got); check("R12 reset request", got, 8'h00);

    initPic(8'h13, 8'h47, 8'h00);
    setIrq(5, 1'b1);
    check("R5 single request", {7'd0, intReq}, 8'h01);
    check("R2 vector", vecOut, 8'h45);

    wr(2'd0, 8'h13);
    check("R1 init drops request", {7'd0, intReq}, 8'h00);
    irqIn = '0;
    wr(2'd1, 8'h47); wr(2'd1, 8'h00);
    initPic(8'h12, 8'h48, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, got); check("R1 no fourth word, mask loads", got, 8'hFF);
    wr(2'd1, 8'h10);
    setIrq(4, 1'b1);
    check("R3 masked line silent", {7'd0, intReq}, 8'h00);
    rd(2'd0, got); check("R3 masked request visible", got, 8'h10);
    wr(2'd1, 8'h00);
    check("R3 unmasked requests", {7'd0, intReq}, 8'h01);
    check("R2 vector base 0x48", vecOut, 8'h4C);

    ackPulse();
    check("R6 ack drops request", {7'd0, intReq}, 8'h00);
    rd(2'd0, got); check("R6 request cleared", got, 8'h00);
    wr(2'd0, 8'h0B);
    rd(2'd0, got); check("R9 R6 in-service read", got, 8'h10);

    setIrq(6, 1'b1);
    check("R5 lower rank blocked", {7'd0, intReq}, 8'h00);
    setIrq(1, 1'b1);
    check("R5 higher rank requests", {7'd0, intReq}, 8'h01);
    check("R5 winner line 1", vecOut, 8'h49);
    ackPulse();
    rd(2'd0, got); check("R6 nested service", got, 8'h12);

    wr(2'd0, 8'h20);
    rd(2'd0, got); check("R7 nonspecific end", got, 8'h10);
    check("R7 line 6 still blocked", {7'd0, intReq}, 8'h00);
    wr(2'd0, 8'hA0);
    rd(2'd0, got); check("R7 rotate end clears", got, 8'h00);
    check("R7 rotate request", {7'd0, intReq}, 8'h01);
    check("R7 winner line 6", vecOut, 8'h4E);

    ackPulse();
    rd(2'd0, got); check("R6 line 6 served", got, 8'h40);
    wr(2'd0, 8'h66);
    rd(2'd0, got); check("R8 specific end", got, 8'h00);
    check("R8 idle after end", {7'd0, intReq}, 8'h00);
    wr(2'd0, 8'hC2);
    setIrq(2, 1'b1); setIrq(3, 1'b1);
    check("R8 set priority winner", vecOut, 8'h4B);
    ackPulse();
    wr(2'd0, 8'hE3);
    rd(2'd0, got); check("R8 rotate specific clears", got, 8'h00);
    setIrq(3, 1'b0); setIrq(3, 1'b1);
    check("R8 rotated base winner", vecOut, 8'h4A);

    wr(2'd0, 8'h0C);
    rd(2'd0, got); check("R10 poll returns line", got, 8'h02);
    wr(2'd0, 8'h0A);
    rd(2'd0, got); check("R10 poll cleared request", got, 8'h08);
    wr(2'd0, 8'h0C);
    rd(2'd0, got); check("R10 poll line 3", got, 8'h03);
    wr(2'd0, 8'h0C);
    rd(2'd0, got); check("R10 poll empty", got, 8'h07);

    initPic(8'h13, 8'h40, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, got); check("R4 trigger mask", got, 8'hF8);
    setIrq(5, 1'b1);
    rd(2'd0, got); check("R4 level set", got, 8'h20);
    setIrq(5, 1'b0);
    rd(2'd0, got); check("R4 level follows", got, 8'h00);
    setIrq(1, 1'b1); setIrq(1, 1'b0);
    rd(2'd0, got); check("R4 edge holds", got, 8'h02);

    initPic(8'h13, 8'h40, 8'h10);
    setIrq(2, 1'b1); ackPulse();
    setIrq(5, 1'b1);
    check("R11 nested ignores line 2", {7'd0, intReq}, 8'h01);
    check("R11 winner line 5", vecOut, 8'h45);
    initPic(8'h13, 8'h40, 8'h00);
    setIrq(2, 1'b1); ackPulse();
    setIrq(5, 1'b1);
    check("R11 without nested blocked", {7'd0, intReq}, 8'h00);

    initPic(8'h13, 8'h40, 8'h02);
    setIrq(6, 1'b1); ackPulse();
    wr(2'd0, 8'h0B);
    rd(2'd0, got); check("R6 auto end no service", got, 8'h00);
    wr(2'd0, 8'h0A);
    rd(2'd0, got); check("R6 auto end request cleared", got, 8'h00);

    initPic(8'h13, 8'h40, 8'h00);
    wr(2'd2, 8'hF8);
    for (int n = 0; n < 40; n++) begin
      logic [7:0] m, v;
      int p, w;
      m = 8'($urandom);
      p = int'($urandom % 8);
      v = 8'($urandom) & 8'hF8;
      wr(2'd1, m);
      wr(2'd0, {5'b11000, 3'(p)});
      irqIn = v;
      @(negedge clk);
      w = expWin(v & ~m, (p + 1) % 8);
      check("R5 R3 R4 random request", {7'd0, intReq}, (w >= 0) ? 8'h01 : 8'h00);
      if (w >= 0) check("R5 random winner", vecOut, 8'h40 | 8'(w));
    end

    finishRun();
  end
endmodule